// File: doc/BRIEF.md
# LIN Bus Remote Wake-Up Detector

This block watches the digitised LIN bus level while the transceiver is in its low-power state and decides whether a remote node has asked for a wake-up. The raw bus level first passes a two-flop synchroniser and a debounce filter that drops any level change shorter than a set number of clock cycles. A falling edge of the filtered level starts a dominant-time measurement. If the bus stays dominant long enough, the block raises a wake pin that turns the voltage regulator on, and a wake flag that the microcontroller can read once it is running.

If the bus returns to recessive before the minimum dominant time, the measurement is dropped. The next filtered falling edge restarts it from zero. Detection runs only while the mode controller reports sleep and the enable input is low. In normal operation the same filtered level is forwarded as receive data, gated so that the microcontroller sees a recessive level unless the regulator is on and enable is high. The debounce length and the minimum dominant time are parameters counted in reference-clock cycles.

Top module: `lin_wake_detect`

## Requirements
- R1: After reset, `wake_flag_o` and `wake_pin_o` are 0 and `rxd_o` is 1 (recessive).
- R2: A bus level (1 = recessive, 0 = dominant) that holds for fewer than DEB_CYCLES synchronised clock cycles changes neither the receive data nor the wake detection. A level that holds for exactly DEB_CYCLES cycles is accepted.
- R3: With the path open, a bus change shows up on `rxd_o` at the (DEB_CYCLES+3)-th rising clock edge after the change. The delay is the same for falling and rising edges.
- R4: While `reg_on_i` or `en_i` is 0, `rxd_o` is 1 whatever the bus does.
- R5: Detection is armed when `sleep_i`=1 and `en_i`=0. After a filtered falling edge, a dominant level held for WAKE_CYCLES+1 bus cycles raises `wake_pin_o` and `wake_flag_o` at the (DEB_CYCLES+WAKE_CYCLES+3)-th rising edge after the bus fell. A dominant level of only WAKE_CYCLES cycles raises neither.
- R6: A return to recessive before the dominant time is reached cancels the measurement. The next falling edge restarts the count from zero.
- R7: No wake-up is recognised while `en_i`=1 or `sleep_i`=0. A dominant level that began before sleep was entered does not wake the block, because a falling edge is required.
- R8: `wake_flag_o` stays 1 until reset. `wake_pin_o` drops to 0 on the first rising edge at which `sleep_i` is 0, while the flag stays set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset (supply restart) |
| bus_i | input | 1 | Digitised bus level, 1 = recessive, 0 = dominant |
| sleep_i | input | 1 | Mode controller reports the low-power state |
| en_i | input | 1 | Enable input from the microcontroller |
| reg_on_i | input | 1 | Voltage regulator is on |
| rxd_o | output | 1 | Filtered, gated receive data |
| wake_flag_o | output | 1 | Wake-up seen since reset (sticky) |
| wake_pin_o | output | 1 | Wake request to the regulator, held while sleeping |

## Verification
A debounce counter that fails to clear on a matching sample shows up as a short glitch on `rxd_o`, about DEB_CYCLES+3 edges after the bus change. A timer that keeps its count across a cancelled pulse raises `wake_pin_o` too early on the next dominant phase. An exact-edge check catches this in the cycle it happens. A state machine stuck in its woken state keeps `wake_pin_o` high one edge after sleep ends, and a flag that is not sticky drops to 0 in that same edge. Because the reference model is compared every clock, any of these divergences is reported in the first cycle in which an output differs.

// File: rtl/lwd_pkg.sv
package lwd_pkg;

    typedef enum logic [1:0] {
        WK_IDLE = 2'd0,
        WK_MEAS = 2'd1,
        WK_WOKE = 2'd2
    } wk_state_e;

endpackage

// File: rtl/lwd_deglitch.sv
module lwd_deglitch #(
    parameter int DEB_CYCLES = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bus_i,
    output logic level_o,
    output logic fall_o
);
    localparam int CW = $clog2(DEB_CYCLES + 1);

    typedef struct packed {
        logic          sy1;
        logic          sy2;
        logic          lvl;
        logic          fall;
        logic [CW-1:0] cnt;
    } dg_t;

    localparam dg_t DG_RST = '{sy1: 1'b1, sy2: 1'b1, lvl: 1'b1, fall: 1'b0, cnt: '0};

    dg_t r_q, r_d;

    always_comb begin
        r_d      = r_q;
        r_d.sy1  = bus_i;
        r_d.sy2  = r_q.sy1;
        r_d.fall = 1'b0;
        if (r_q.sy2 != r_q.lvl) begin
            if (r_q.cnt == CW'(DEB_CYCLES - 1)) begin
                r_d.lvl  = r_q.sy2;
                r_d.cnt  = '0;
                r_d.fall = ~r_q.sy2;
            end else begin
                r_d.cnt = r_q.cnt + 1'b1;
            end
        end else begin
            r_d.cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= DG_RST;
        else        r_q <= r_d;
    end

    assign level_o = r_q.lvl;
    assign fall_o  = r_q.fall;

    // R2: run counter never reaches the debounce length
    a_r2_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.cnt < CW'(DEB_CYCLES));

    // R2: a synchronised sample equal to the filtered level cannot move it
    a_r2_level_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.sy2 == r_q.lvl) |=> $stable(level_o));

endmodule

// File: rtl/lwd_wake_fsm.sv
module lwd_wake_fsm
    import lwd_pkg::*;
#(
    parameter int WAKE_CYCLES = 60
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm_i,
    input  logic sleep_i,
    input  logic level_i,
    input  logic fall_i,
    output logic wake_flag_o,
    output logic wake_pin_o
);
    localparam int TW = $clog2(WAKE_CYCLES + 1);

    typedef struct packed {
        wk_state_e     st;
        logic [TW-1:0] tmr;
        logic          flag;
        logic          pin;
    } wk_t;

    localparam wk_t WK_RST = '{st: WK_IDLE, tmr: '0, flag: 1'b0, pin: 1'b0};

    wk_t  r_q, r_d;
    logic evt;

    always_comb begin
        r_d = r_q;
        evt = 1'b0;
        case (r_q.st)
            WK_IDLE: begin
                if (arm_i && fall_i) begin
                    r_d.st  = WK_MEAS;
                    r_d.tmr = '0;
                end
            end
            WK_MEAS: begin
                if (!arm_i || level_i) begin
                    r_d.st = WK_IDLE;
                end else if (r_q.tmr == TW'(WAKE_CYCLES - 1)) begin
                    r_d.st = WK_WOKE;
                    evt    = 1'b1;
                end else begin
                    r_d.tmr = r_q.tmr + 1'b1;
                end
            end
            WK_WOKE: begin
                if (!sleep_i) r_d.st = WK_IDLE;
            end
            default: r_d.st = WK_IDLE;
        endcase
        r_d.flag = r_q.flag | evt;
        r_d.pin  = evt | (r_q.pin & sleep_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= WK_RST;
        else        r_q <= r_d;
    end

    assign wake_flag_o = r_q.flag;
    assign wake_pin_o  = r_q.pin;

    // R6: dominant timer stays inside its window
    a_r6_tmr_bound: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.tmr < TW'(WAKE_CYCLES));

    // R7: a wake can only be raised while detection is armed
    a_r7_rise_needs_arm: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wake_pin_o) |-> $past(arm_i));

    // R5: a wake is only raised on a dominant filtered level
    a_r5_rise_on_dominant: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wake_pin_o) |-> !$past(level_i));

    // R8: flag is sticky
    a_r8_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        wake_flag_o |=> wake_flag_o);

    // R8: pin never stands without the flag
    a_r8_pin_has_flag: assert property (@(posedge clk) disable iff (!rst_n)
        wake_pin_o |-> wake_flag_o);

    // R8: leaving sleep clears the pin on the next edge
    a_r8_pin_clear: assert property (@(posedge clk) disable iff (!rst_n)
        !sleep_i |=> !wake_pin_o);

endmodule

// File: rtl/lwd_rx_gate.sv
module lwd_rx_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic level_i,
    input  logic reg_on_i,
    input  logic en_i,
    output logic rxd_o
);
    typedef struct packed {
        logic rxd;
    } rx_t;

    rx_t r_q, r_d;

    always_comb begin
        r_d     = r_q;
        r_d.rxd = (reg_on_i && en_i) ? level_i : 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{rxd: 1'b1};
        else        r_q <= r_d;
    end

    assign rxd_o = r_q.rxd;

    // R4: closed path shows recessive on the next edge
    a_r4_gated: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_on_i && en_i) |=> rxd_o);

endmodule

// File: rtl/lin_wake_detect.sv
module lin_wake_detect #(
    parameter int DEB_CYCLES  = 8,
    parameter int WAKE_CYCLES = 60
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bus_i,
    input  logic sleep_i,
    input  logic en_i,
    input  logic reg_on_i,
    output logic rxd_o,
    output logic wake_flag_o,
    output logic wake_pin_o
);
    logic lvl;
    logic fall;
    logic arm;

    assign arm = sleep_i & ~en_i;

    lwd_deglitch #(.DEB_CYCLES(DEB_CYCLES)) u_dg (
        .clk     (clk),
        .rst_n   (rst_n),
        .bus_i   (bus_i),
        .level_o (lvl),
        .fall_o  (fall)
    );

    lwd_wake_fsm #(.WAKE_CYCLES(WAKE_CYCLES)) u_wk (
        .clk         (clk),
        .rst_n       (rst_n),
        .arm_i       (arm),
        .sleep_i     (sleep_i),
        .level_i     (lvl),
        .fall_i      (fall),
        .wake_flag_o (wake_flag_o),
        .wake_pin_o  (wake_pin_o)
    );

    lwd_rx_gate u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .level_i  (lvl),
        .reg_on_i (reg_on_i),
        .en_i     (en_i),
        .rxd_o    (rxd_o)
    );

    // R1: outputs idle right after reset release
    a_r1_idle_after_reset: assert property (@(posedge clk)
        $rose(rst_n) |-> (!wake_flag_o && !wake_pin_o && rxd_o));

endmodule

// File: tb/sim_lin_wake_detect.sv
module sim_lin_wake_detect;
    localparam int CLK_PERIOD = 10;
    localparam int DEB  = 8;
    localparam int WAKE = 60;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus = 1'b1, slp = 1'b0, en = 1'b0, ron = 1'b0;
    logic rxd, wflag, wpin;

    int    errors = 0;
    int    checks = 0;
    string cur_req = "R1";

    always #(CLK_PERIOD/2) clk = ~clk;

    lin_wake_detect #(.DEB_CYCLES(DEB), .WAKE_CYCLES(WAKE)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_i(bus), .sleep_i(slp), .en_i(en),
        .reg_on_i(ron), .rxd_o(rxd), .wake_flag_o(wflag), .wake_pin_o(wpin)
    );

    // behavioural reference model
    bit bq[$];
    bit sh[$];
    bit m_filt, m_fall, m_woke, m_flag, m_pin, m_rxd;
    int m_dom;

    always @(posedge clk or negedge rst_n) begin : mdl
        bit s;
        bit all_diff;
        bit armed;
        if (!rst_n) begin
            bq = {1'b1, 1'b1};
            sh = {};
            m_filt = 1; m_fall = 0; m_woke = 0; m_flag = 0; m_pin = 0; m_rxd = 1;
            m_dom = -1;
        end else begin
            s = bq[bq.size()-2];
            bq.push_back(bus);
            if (bq.size() > 4) void'(bq.pop_front());
            m_rxd = (ron && en) ? m_filt : 1'b1;
            armed = slp && !en;
            if (m_woke) begin
                if (!slp) begin m_woke = 0; m_dom = -1; end
                m_pin = m_pin & slp;
            end else begin
                if (!armed) m_dom = -1;
                else if (m_dom >= 0) begin
                    if (m_filt == 1'b0) m_dom++;
                    else m_dom = -1;
                end else if (m_fall) m_dom = 0;
                if (m_dom == WAKE) begin
                    m_woke = 1; m_flag = 1; m_pin = 1; m_dom = -1;
                end else begin
                    m_pin = m_pin & slp;
                end
            end
            sh.push_back(s);
            if (sh.size() > DEB) void'(sh.pop_front());
            all_diff = (sh.size() == DEB);
            foreach (sh[i]) if (sh[i] == m_filt) all_diff = 0;
            m_fall = 0;
            if (all_diff) begin
                m_fall = (m_filt == 1'b1) && (s == 1'b0);
                m_filt = s;
            end
        end
    end

    task automatic chk(string req, string what, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0b expected=%0b at %0t", req, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            chk(cur_req, "model rxd", rxd, m_rxd);
            chk(cur_req, "model flag", wflag, m_flag);
            chk(cur_req, "model pin", wpin, m_pin);
        end
    end

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic edges_then_sample(int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : stim
        bit seen_low;
        cyc(2);
        // R1 reset state
        chk("R1", "rxd", rxd, 1'b1);
        chk("R1", "flag", wflag, 1'b0);
        chk("R1", "pin", wpin, 1'b0);
        do_reset();
        cyc(1);
        chk("R1", "flag after reset", wflag, 1'b0);

        // R3 latency, both directions
        cur_req = "R3";
        ron = 1; en = 1; slp = 0; bus = 1;
        cyc(20);
        bus = 0;
        edges_then_sample(DEB + 2);
        chk("R3", "fall not early", rxd, 1'b1);
        edges_then_sample(1);
        chk("R3", "fall on time", rxd, 1'b0);
        cyc(20);
        bus = 1;
        edges_then_sample(DEB + 2);
        chk("R3", "rise not early", rxd, 1'b0);
        edges_then_sample(1);
        chk("R3", "rise on time", rxd, 1'b1);
        for (int k = 0; k < 6; k++) begin
            bus = ~bus;
            cyc(DEB + 5 + k);
        end
        bus = 1;
        cyc(30);

        // R2 glitches shorter than the debounce length
        cur_req = "R2";
        seen_low = 0;
        for (int k = 0; k < 5; k++) begin
            bus = 0;
            for (int j = 0; j < DEB - 1; j++) begin
                @(negedge clk); if (!rxd) seen_low = 1;
            end
            bus = 1;
            for (int j = 0; j < 6; j++) begin
                @(negedge clk); if (!rxd) seen_low = 1;
            end
        end
        for (int j = 0; j < DEB + 4; j++) begin
            @(negedge clk); if (!rxd) seen_low = 1;
        end
        chk("R2", "short pulses filtered", seen_low, 1'b0);
        bus = 0;
        cyc(DEB);
        bus = 1;
        seen_low = 0;
        for (int j = 0; j < DEB + 6; j++) begin
            @(negedge clk); if (!rxd) seen_low = 1;
        end
        chk("R2", "exact-length pulse accepted", seen_low, 1'b1);

        // R4 gating
        cur_req = "R4";
        en = 0;
        bus = 0; cyc(DEB + 10);
        chk("R4", "en low gates", rxd, 1'b1);
        bus = 1; cyc(DEB + 10);
        ron = 0; en = 1;
        bus = 0; cyc(DEB + 10);
        chk("R4", "reg off gates", rxd, 1'b1);
        bus = 1; cyc(DEB + 10);

        // R5 exact wake timing
        cur_req = "R5";
        do_reset();
        ron = 0; en = 0; slp = 1; bus = 1;
        cyc(20);
        bus = 0;
        edges_then_sample(DEB + WAKE + 2);
        chk("R5", "pin not early", wpin, 1'b0);
        edges_then_sample(1);
        chk("R5", "pin on time", wpin, 1'b1);
        chk("R5", "flag on time", wflag, 1'b1);
        bus = 1;
        cyc(20);

        // R5 minimum length boundary
        do_reset();
        slp = 1; en = 0; bus = 1;
        cyc(20);
        bus = 0; cyc(WAKE); bus = 1;
        cyc(WAKE + DEB + 20);
        chk("R5", "WAKE-long pulse no wake", wpin, 1'b0);
        bus = 0; cyc(WAKE + 1); bus = 1;
        cyc(DEB + 10);
        chk("R5", "WAKE+1 pulse wakes", wpin, 1'b1);

        // R6 cancel and restart
        cur_req = "R6";
        do_reset();
        slp = 1; en = 0; bus = 1;
        cyc(20);
        bus = 0; cyc(WAKE / 2); bus = 1;
        cyc(20);
        chk("R6", "cancelled no pin", wpin, 1'b0);
        bus = 0;
        edges_then_sample(DEB + WAKE + 2);
        chk("R6", "restart not early", wpin, 1'b0);
        edges_then_sample(1);
        chk("R6", "restart on time", wpin, 1'b1);
        bus = 1; cyc(20);

        // R7 not armed
        cur_req = "R7";
        do_reset();
        slp = 1; en = 1; bus = 1;
        cyc(20);
        bus = 0; cyc(WAKE * 3);
        chk("R7", "en high no wake", wflag, 1'b0);
        bus = 1; cyc(20);
        slp = 0; en = 0;
        bus = 0; cyc(WAKE * 3);
        chk("R7", "not sleeping no wake", wflag, 1'b0);
        slp = 1;
        cyc(WAKE * 3);
        chk("R7", "no falling edge no wake", wflag, 1'b0);
        bus = 1; cyc(20);
        bus = 0; cyc(WAKE + DEB + 10);
        chk("R7", "edge in sleep wakes", wflag, 1'b1);

        // R8 pin release and sticky flag
        cur_req = "R8";
        slp = 0;
        edges_then_sample(1);
        chk("R8", "pin cleared", wpin, 1'b0);
        chk("R8", "flag kept", wflag, 1'b1);
        bus = 1; cyc(20);
        slp = 1; cyc(50);
        chk("R8", "flag still kept", wflag, 1'b1);
        chk("R8", "pin stays low", wpin, 1'b0);
        do_reset();
        cyc(1);
        chk("R8", "flag cleared by reset", wflag, 1'b0);
        cyc(5);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule